// File: doc/BRIEF.md
# Watchdog Timer with APB Register Interface

The block is a watchdog counter for a peripheral bus. Software writes a reload value and turns on the timer. From then on, the counter steps down once for each cycle in which the count-enable input is high. When the counter expires it reloads itself and raises an interrupt. If software has not acknowledged that interrupt by the following expiry, the block raises a reset request, provided resets are enabled. A key register guards the whole register file against stray writes.

A compile-time parameter `VARIANT` selects one of two register-compatible personalities. In the sticky personality (`VARIANT=1`), the interrupt enable cannot be turned off again once it is set. That personality also drops the output-forcing test registers, adds a dummy test register, and returns a different set of identification bytes. The APB interface has no wait states. Read data is a combinational function of the address and the register state, and a write takes effect on the clock edge of its access phase. All offsets below are byte offsets; the port `paddr` carries byte address bits 11 to 2.

Top module: `apb_watchdog`

## Requirements
- R1: After reset, offset 0x00 (reload) and offset 0x04 (current count) read 0xFFFFFFFF. Offset 0x08 (control) reads 0, offset 0xC00 (key) reads 0 (unlocked), and `irq_o` and `wdog_rst_o` are low.
- R2: While control bit 0 is 1 and `cnt_en` is high, the count at 0x04 drops by one on each clock. When a clock finds the count at 0 under those conditions, the count reloads from 0x00 and raw status bit 0 at 0x10 becomes 1. With `cnt_en` low or control bit 0 clear, the count holds.
- R3: A write to 0x00 sets both the reload value and the count. Any write to 0x0C clears raw status and reloads the count from 0x00. Offset 0x0C reads 0.
- R4: Offset 0x14 reads raw status AND control bit 0. Outside forced-output mode, `irq_o` equals that value.
- R5: An expiry while raw status is already 1 and control bit 1 is 1 sets `wdog_rst_o`. It stays high until `rst_n` is asserted.
- R6: Writing 0x1ACCE551 to 0xC00 unlocks the register file, and any other value locks it. 0xC00 reads 1 when locked and 0 when unlocked. While locked, writes to every other offset are ignored.
- R7: With `VARIANT=1`, once control bit 0 is 1, writes to 0x08 are ignored. With `VARIANT=0`, writes to 0x08 always take bits [1:0].
- R8: With `VARIANT=0`, setting bit 0 of 0xF00 makes `wdog_rst_o` follow bit 0 of 0xF04 and `irq_o` follow bit 1 of 0xF04. 0xF00 reads back its bit 0, and 0xF04 reads 0. With `VARIANT=1`, both offsets read 0 and writes to them change neither output.
- R9: Offset 0x418 reads 0 in both personalities, and a write to it changes no other register.
- R10: Offsets 0xFD0 to 0xFFC return one identification byte each in bits [7:0]. For `VARIANT=0` the bytes, in address order, are 04 00 00 00 24 B8 1B 00 0D F0 05 B1. For `VARIANT=1` they are 00 00 00 00 05 18 18 01 0D F0 05 B1.
- R11: Unmapped offsets read 0, and writes to them are ignored. Writes to the read-only offsets 0x04, 0x10, 0x14 and 0xFD0 to 0xFFC are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | 10 | APB byte address bits 11:2 |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| cnt_en | input | 1 | Count enable, one count step per high cycle |
| irq_o | output | 1 | Timeout interrupt |
| wdog_rst_o | output | 1 | Reset request |

## Verification
The bench runs both personalities side by side from the same bus stimulus. It targets the following cases:
- Expiry on the exact cycle the count reaches zero. A design off by one would raise the interrupt a tick early or late.
- A second expiry with the interrupt still pending. A design that lost the pending flag would never request reset, or would request it on the first expiry.
- The key register. A design that checked the key only against part of its bits would accept stray writes.
- The sticky enable and the personality-only offsets. A design that mixed them up would let software disable a sticky watchdog, or let the test registers force the outputs in the personality that lacks them.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DATA_W = 32;
  localparam int AW     = 10;

  // word offsets (byte offset >> 2)
  localparam logic [AW-1:0] OFS_RELOAD = 10'h000;
  localparam logic [AW-1:0] OFS_COUNT  = 10'h001;
  localparam logic [AW-1:0] OFS_CTRL   = 10'h002;
  localparam logic [AW-1:0] OFS_ACK    = 10'h003;
  localparam logic [AW-1:0] OFS_RAW    = 10'h004;
  localparam logic [AW-1:0] OFS_MSK    = 10'h005;
  localparam logic [AW-1:0] OFS_DUMMY  = 10'h106;
  localparam logic [AW-1:0] OFS_KEY    = 10'h300;
  localparam logic [AW-1:0] OFS_FCTL   = 10'h3C0;
  localparam logic [AW-1:0] OFS_FVAL   = 10'h3C1;
  localparam logic [AW-1:0] OFS_IDBASE = 10'h3F4;
  localparam int            ID_COUNT   = 12;

  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h1ACCE551;
endpackage

// File: rtl/wdog_id_rom.sv
module wdog_id_rom #(
  parameter bit VARIANT = 1'b0
) (
  input  logic [3:0] idx,
  output logic [7:0] val
);
  generate
    if (VARIANT) begin : g_sticky
      always_comb begin
        case (idx)
          4'd4:    val = 8'h05;
          4'd5:    val = 8'h18;
          4'd6:    val = 8'h18;
          4'd7:    val = 8'h01;
          4'd8:    val = 8'h0D;
          4'd9:    val = 8'hF0;
          4'd10:   val = 8'h05;
          4'd11:   val = 8'hB1;
          default: val = 8'h00;
        endcase
      end
    end else begin : g_base
      always_comb begin
        case (idx)
          4'd0:    val = 8'h04;
          4'd4:    val = 8'h24;
          4'd5:    val = 8'hB8;
          4'd6:    val = 8'h1B;
          4'd8:    val = 8'h0D;
          4'd9:    val = 8'hF0;
          4'd10:   val = 8'h05;
          4'd11:   val = 8'hB1;
          default: val = 8'h00;
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_reload,
  input  logic [CNT_W-1:0] wr_val,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             expire
);
  assign expire = tick && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '1;
    else if (wr_reload) cnt_q <= wr_val;
    else if (tick)      cnt_q <= (cnt_q == '0) ? load_val : cnt_q - 1'b1;
  end

  // R2
  cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_reload && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_reload) |=> $stable(cnt_q));

  // R2
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !wr_reload) |=> cnt_q == $past(load_val));
endmodule

// File: rtl/wdog_csr.sv
module wdog_csr
  import wdog_pkg::*;
#(
  parameter bit VARIANT = 1'b0,
  parameter int CNT_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [AW-1:0]     paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic              expire,
  output logic [CNT_W-1:0]  load_q,
  output logic [1:0]        ctrl_q,
  output logic              raw_q,
  output logic              rst_flag_q,
  output logic              fctl_q,
  output logic [1:0]        fval_q,
  output logic              wr_reload,
  output logic [CNT_W-1:0]  wr_val
);
  logic       wr_en, acc, lock_q, ctrl_ok, in_id;
  logic [7:0] id_val;
  logic [3:0] id_idx;
  logic [AW-1:0] id_off;

  assign wr_en   = psel && penable && pwrite;
  assign acc     = wr_en && !lock_q;
  assign ctrl_ok = acc && (paddr == OFS_CTRL) && !(VARIANT && ctrl_q[0]);

  assign wr_reload = acc && ((paddr == OFS_RELOAD) || (paddr == OFS_ACK));
  assign wr_val    = (paddr == OFS_RELOAD) ? pwdata[CNT_W-1:0] : load_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= 1'b0;
    else if (wr_en && paddr == OFS_KEY) lock_q <= (pwdata != UNLOCK_KEY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) load_q <= '1;
    else if (acc && paddr == OFS_RELOAD) load_q <= pwdata[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= 2'b00;
    else if (ctrl_ok) ctrl_q <= pwdata[1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       raw_q <= 1'b0;
    else if (acc && paddr == OFS_ACK) raw_q <= 1'b0;
    else if (expire)                  raw_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_flag_q <= 1'b0;
    else if (expire && raw_q && ctrl_q[1]) rst_flag_q <= 1'b1;
  end

  generate
    if (VARIANT) begin : g_no_force
      assign fctl_q = 1'b0;
      assign fval_q = 2'b00;
    end else begin : g_force
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          fctl_q <= 1'b0;
          fval_q <= 2'b00;
        end else if (acc && paddr == OFS_FCTL) begin
          fctl_q <= pwdata[0];
        end else if (acc && paddr == OFS_FVAL) begin
          fval_q <= pwdata[1:0];
        end
      end
    end
  endgenerate

  assign id_off = paddr - OFS_IDBASE;
  assign id_idx = id_off[3:0];
  assign in_id  = (paddr >= OFS_IDBASE);

  wdog_id_rom #(.VARIANT(VARIANT)) u_id (.idx(id_idx), .val(id_val));

  always_comb begin
    prdata = '0;
    if (in_id) prdata = {{(DATA_W-8){1'b0}}, id_val};
    else begin
      case (paddr)
        OFS_RELOAD: prdata = DATA_W'(load_q);
        OFS_COUNT:  prdata = DATA_W'(cnt_q);
        OFS_CTRL:   prdata = {{(DATA_W-2){1'b0}}, ctrl_q};
        OFS_RAW:    prdata = {{(DATA_W-1){1'b0}}, raw_q};
        OFS_MSK:    prdata = {{(DATA_W-1){1'b0}}, raw_q & ctrl_q[0]};
        OFS_KEY:    prdata = {{(DATA_W-1){1'b0}}, lock_q};
        OFS_FCTL:   prdata = {{(DATA_W-1){1'b0}}, fctl_q};
        default:    prdata = '0; // includes ack, force value, dummy test offset
      endcase
    end
  end

  // R2
  raw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !(acc && paddr == OFS_ACK)) |=> raw_q);

  // R5
  rst_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(rst_flag_q));

  // R6
  lock_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && wr_en && paddr != OFS_KEY) |=> ($stable(load_q) && $stable(ctrl_q)));

  generate
    if (VARIANT) begin : g_sticky_chk
      // R7
      ctrl_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[0] |=> $stable(ctrl_q));
    end
  endgenerate
endmodule

// File: rtl/apb_watchdog.sv
module apb_watchdog
  import wdog_pkg::*;
#(
  parameter bit VARIANT = 1'b0,
  parameter int CNT_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [AW-1:0]     paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  input  logic              cnt_en,
  output logic              irq_o,
  output logic              wdog_rst_o
);
  logic [CNT_W-1:0] cnt_q, load_q, wr_val;
  logic [1:0]       ctrl_q, fval_q;
  logic             expire, raw_q, rst_flag_q, fctl_q, wr_reload, tick;

  assign tick = ctrl_q[0] && cnt_en;

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_reload(wr_reload),
    .wr_val(wr_val), .load_val(load_q), .cnt_q(cnt_q), .expire(expire)
  );

  wdog_csr #(.VARIANT(VARIANT), .CNT_W(CNT_W)) u_csr (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .cnt_q(cnt_q),
    .expire(expire), .load_q(load_q), .ctrl_q(ctrl_q), .raw_q(raw_q),
    .rst_flag_q(rst_flag_q), .fctl_q(fctl_q), .fval_q(fval_q),
    .wr_reload(wr_reload), .wr_val(wr_val)
  );

  generate
    if (VARIANT) begin : g_out_sticky
      assign irq_o      = raw_q & ctrl_q[0];
      assign wdog_rst_o = rst_flag_q;
    end else begin : g_out_base
      assign irq_o      = fctl_q ? fval_q[1] : (raw_q & ctrl_q[0]);
      assign wdog_rst_o = fctl_q ? fval_q[0] : rst_flag_q;
    end
  endgenerate

  // R4
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fctl_q && !ctrl_q[0]) |-> !irq_o);
endmodule

// File: tb/apb_watchdog_tb.sv
module apb_watchdog_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic psel = 0, penable = 0, pwrite = 0, cnt_en = 0;
  logic [9:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prd [2];
  logic irq [2], wrst [2];
  int checks = 0, fails = 0, cycles = 0;
  bit live = 0;

  always #10 clk = ~clk;

  apb_watchdog #(.VARIANT(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prd[0]), .cnt_en(cnt_en),
    .irq_o(irq[0]), .wdog_rst_o(wrst[0]));
  apb_watchdog #(.VARIANT(1'b1)) u_dut_alt (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prd[1]), .cnt_en(cnt_en),
    .irq_o(irq[1]), .wdog_rst_o(wrst[1]));

  // identification bytes, per personality
  logic [7:0] id_tab [2][12];
  initial begin
    id_tab[0] = '{8'h04,8'h00,8'h00,8'h00,8'h24,8'hB8,8'h1B,8'h00,8'h0D,8'hF0,8'h05,8'hB1};
    id_tab[1] = '{8'h00,8'h00,8'h00,8'h00,8'h05,8'h18,8'h18,8'h01,8'h0D,8'hF0,8'h05,8'hB1};
  end

  // behavioural reference, one per personality
  logic [31:0] m_load [2], m_cnt [2];
  logic [1:0]  m_ctrl [2], m_fval [2];
  logic        m_raw [2], m_rst [2], m_lock [2], m_fctl [2];

  always @(posedge clk or negedge rst_n) begin
    for (int m = 0; m < 2; m++) begin
      if (!rst_n) begin
        m_load[m] = 32'hFFFF_FFFF; m_cnt[m] = 32'hFFFF_FFFF; m_ctrl[m] = 0;
        m_raw[m] = 0; m_rst[m] = 0; m_lock[m] = 0; m_fctl[m] = 0; m_fval[m] = 0;
      end else begin
        logic [31:0] ncnt; logic nraw, nrst;
        ncnt = m_cnt[m]; nraw = m_raw[m]; nrst = m_rst[m];
        if (m_ctrl[m][0] && cnt_en) begin
          if (m_cnt[m] == 0) begin
            ncnt = m_load[m]; nraw = 1;
            if (m_raw[m] && m_ctrl[m][1]) nrst = 1;
          end else ncnt = m_cnt[m] - 1;
        end
        if (psel && penable && pwrite) begin
          if (paddr == 10'h300) m_lock[m] = (pwdata != 32'h1ACCE551);
          else if (!m_lock[m]) begin
            case (paddr)
              10'h000: begin m_load[m] = pwdata; ncnt = pwdata; end
              10'h002: if (!(m == 1 && m_ctrl[m][0])) m_ctrl[m] = pwdata[1:0];
              10'h003: begin nraw = 0; ncnt = m_load[m]; end
              10'h3C0: if (m == 0) m_fctl[m] = pwdata[0];
              10'h3C1: if (m == 0) m_fval[m] = pwdata[1:0];
              default: ;
            endcase
          end
        end
        m_cnt[m] = ncnt; m_raw[m] = nraw; m_rst[m] = nrst;
      end
    end
  end

  function automatic logic [31:0] m_read(int m, logic [9:0] a);
    if (a >= 10'h3F4) return {24'h0, id_tab[m][a - 10'h3F4]};
    case (a)
      10'h000: return m_load[m];
      10'h001: return m_cnt[m];
      10'h002: return {30'h0, m_ctrl[m]};
      10'h004: return {31'h0, m_raw[m]};
      10'h005: return {31'h0, m_raw[m] & m_ctrl[m][0]};
      10'h300: return {31'h0, m_lock[m]};
      10'h3C0: return {31'h0, m_fctl[m]};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(logic [9:0] a);
    case (a)
      10'h000, 10'h003: return "R3";
      10'h001, 10'h004: return "R2";
      10'h005: return "R4";
      10'h002: return "R7";
      10'h300: return "R6";
      10'h3C0, 10'h3C1: return "R8";
      10'h106: return "R9";
      default: return (a >= 10'h3F4) ? "R10" : "R11";
    endcase
  endfunction

  task automatic chk(string tag, int m, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s inst=%0d actual=%h expected=%h t=%0t", tag, m, got, exp, $time);
    end
  endtask

  // per-clock comparison against the reference
  always @(negedge clk) begin
    if (live && rst_n) begin
      for (int m = 0; m < 2; m++) begin
        logic ei, er;
        ei = m_fctl[m] ? m_fval[m][1] : (m_raw[m] & m_ctrl[m][0]);
        er = m_fctl[m] ? m_fval[m][0] : m_rst[m];
        chk("R4", m, {31'h0, irq[m]}, {31'h0, ei});
        chk("R5", m, {31'h0, wrst[m]}, {31'h0, er});
        chk(tag_of(paddr), m, prd[m], m_read(m, paddr));
      end
    end
  end

  task automatic wr(logic [9:0] a, logic [31:0] d);
    @(negedge clk); #1 psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); #1 penable = 1;
    @(negedge clk); #1 psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(logic [9:0] a, logic [31:0] e0, logic [31:0] e1, string tag);
    @(negedge clk); #1 psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk); #1 penable = 1;
    #4 chk(tag, 0, prd[0], e0); chk(tag, 1, prd[1], e1);
    @(negedge clk); #1 psel = 0; penable = 0;
  endtask

  task automatic pins(logic i0, logic i1, logic r0, logic r1, string tag);
    @(negedge clk); #2;
    chk(tag, 0, {31'h0, irq[0]}, {31'h0, i0}); chk(tag, 1, {31'h0, irq[1]}, {31'h0, i1});
    chk(tag, 0, {31'h0, wrst[0]}, {31'h0, r0}); chk(tag, 1, {31'h0, wrst[1]}, {31'h0, r1});
  endtask

  task automatic do_reset();
    @(negedge clk); #1 rst_n = 0; cnt_en = 0; psel = 0; penable = 0; pwrite = 0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
  endtask

  initial begin
    forever begin
      @(posedge clk); cycles++;
      if (cycles > 20000) begin
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    do_reset(); live = 1;
    // R1 reset state
    rd(10'h000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R1");
    rd(10'h001, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R1");
    rd(10'h002, 0, 0, "R1");
    rd(10'h300, 0, 0, "R1");
    pins(0, 0, 0, 0, "R1");
    // R2 expiry sets raw status, R4 masked output
    wr(10'h000, 5); wr(10'h002, 1);
    #0 cnt_en = 1; repeat (20) @(negedge clk); #1 cnt_en = 0;
    pins(1, 1, 0, 0, "R4");
    rd(10'h005, 1, 1, "R4");
    rd(10'h004, 1, 1, "R2");
    // R3 ack clears and reloads
    wr(10'h003, 32'hDEAD);
    rd(10'h004, 0, 0, "R3");
    rd(10'h001, 5, 5, "R3");
    rd(10'h003, 0, 0, "R3");
    repeat (5) @(negedge clk);
    rd(10'h001, 5, 5, "R2");
    // R7 sticky enable
    wr(10'h002, 3); rd(10'h002, 3, 1, "R7");
    wr(10'h002, 0); rd(10'h002, 0, 1, "R7");
    wr(10'h002, 3);
    // R5 second expiry with pending interrupt
    #1 cnt_en = 1; repeat (20) @(negedge clk); #1 cnt_en = 0;
    pins(1, 1, 1, 0, "R5");
    wr(10'h003, 0);
    pins(0, 0, 1, 0, "R5");
    // R2 exact step count
    do_reset();
    wr(10'h000, 10); wr(10'h002, 1);
    @(negedge clk); #1 cnt_en = 1;
    repeat (3) @(negedge clk); #1 cnt_en = 0;
    rd(10'h001, 7, 7, "R2");
    // R6 key register
    do_reset();
    wr(10'h300, 0); rd(10'h300, 1, 1, "R6");
    wr(10'h000, 7); rd(10'h000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R6");
    wr(10'h300, 32'h1ACCE550); rd(10'h300, 1, 1, "R6");
    wr(10'h300, 32'h1ACCE551); rd(10'h300, 0, 0, "R6");
    wr(10'h000, 7); rd(10'h000, 7, 7, "R6");
    // R8 forced outputs
    wr(10'h3C1, 3); wr(10'h3C0, 1);
    pins(1, 0, 1, 0, "R8");
    rd(10'h3C0, 1, 0, "R8");
    rd(10'h3C1, 0, 0, "R8");
    wr(10'h3C1, 2); pins(1, 0, 0, 0, "R8");
    wr(10'h3C0, 0); pins(0, 0, 0, 0, "R8");
    // R9 dummy test offset
    wr(10'h106, 32'hFFFF_FFFF);
    rd(10'h106, 0, 0, "R9");
    rd(10'h000, 7, 7, "R9");
    // R11 unmapped and read-only
    wr(10'h080, 32'h1234); rd(10'h080, 0, 0, "R11");
    wr(10'h001, 32'h99);   rd(10'h001, 7, 7, "R11");
    wr(10'h004, 1);        rd(10'h004, 0, 0, "R11");
    wr(10'h3F4, 32'hFF);   rd(10'h3F4, 32'h04, 32'h00, "R11");
    // R10 identification bytes
    for (int i = 0; i < 12; i++)
      rd(10'h3F4 + 10'(i), {24'h0, id_tab[0][i]}, {24'h0, id_tab[1][i]}, "R10");
    live = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule